// File: doc/BRIEF.md
# Pager Receiver Power Sequencer

This block switches an external radio receiver on and off around each receive window. A start request launches six warm-up stages. Two locking stages follow, and then the receiver is reported ready. While the receiver is ready, a rate-change request runs the two locking stages again, and a processing-done request runs three warm-down stages and returns the block to idle.

Every one of the eleven stages has its own configuration word. The word gives the pattern driven on six receiver-control lines, a hold time counted in timing ticks, and a flag that asks for a low-battery sample. Ticks come from a one-cycle strobe derived from a 76.8 kHz timebase. Software loads the stage words through a plain register write port and clears the low-battery status through the same port. A status output shows the current phase and the active stage.

Top module: `pager_rx_seq`

## Requirements
- R1: After reset the block is idle. `phase` is 0, `rx_ctl` is 0, `stage_idx` is 0, `rx_ready` is 0, `bat_low` is 0, and every stage word is 0.
- R2: A `start` pulse while idle enters warm-up stage 0 on the next clock edge, without waiting for a tick. The stages then run in the order 0 to 5 (phase 1) and 6 to 7 (phase 2), and the block then enters ready (phase 3, `rx_ready` 1). `stage_idx` gives the global stage number (0 to 10) while a stage runs, and 0 in idle and ready.
- R3: A stage whose duration field is D ends on its (D+1)-th tick, so D = 0 gives one tick. Clock cycles without `tick` never advance the stage.
- R4: While a stage runs, `rx_ctl` equals bits [5:0] of that stage's word. In ready, `rx_ctl` holds the pattern of stage 7. In idle, `rx_ctl` is 0.
- R5: In ready, a `rate_chg` pulse reruns stages 6 and 7 (phase 2) and then returns to ready.
- R6: In ready, a `proc_done` pulse runs stages 8, 9 and 10 (phase 4) and then returns to idle. If `proc_done` and `rate_chg` arrive in the same cycle, `proc_done` wins.
- R7: `start` is ignored in every phase other than idle. `rate_chg` and `proc_done` are ignored in every phase other than ready.
- R8: When bit 14 of a warm-up or warm-down stage's word is set, the `low_bat` value on the tick that ends that stage is OR-ed into the sticky `bat_low` bit. Bit 14 has no effect in the locking stages.
- R9: A write to address 15 with data bit 0 set clears `bat_low`. The same write with bit 0 clear has no effect. If a battery sample sets the bit in the same cycle as a clear, the set wins.
- R10: A write to address 0 to 10 loads that stage's word. Bits [5:0] hold the pattern, bits [13:6] the duration and bit 14 the battery-check enable. Writes to addresses 11 to 14 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe from the 76.8 kHz timebase |
| start | input | 1 | Receive-window request |
| rate_chg | input | 1 | Symbol-rate change request |
| proc_done | input | 1 | Signal processing for the window is complete |
| low_bat | input | 1 | Low-battery comparator level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 15 | Register write data |
| rx_ctl | output | 6 | Receiver control lines |
| phase | output | 3 | 0 idle, 1 warm-up, 2 lock, 3 ready, 4 warm-down |
| stage_idx | output | 4 | Active stage number |
| rx_ready | output | 1 | Receiver is ready |
| bat_low | output | 1 | Sticky low-battery status |

## Verification
The assertions assume that every control input is synchronous to `clk`, that reset is applied before the first check, and that `tick` is a single-cycle strobe. They do not assume that the requests arrive only in their legal phases. The stimulus therefore fires `start`, `rate_chg` and `proc_done` during warm-up to show that they are ignored there. Stage words are written only while the block is idle, so a pattern never changes under a running stage. Patterns, durations, battery-check enables, `low_bat` levels and clear writes are drawn at random, and a one-tick stage and a 256-tick stage are placed on purpose.

// File: rtl/pager_rx_seq.sv
module pager_rx_seq #(
  parameter int LINES    = 6,
  parameter int DUR_W    = 8,
  parameter int WU_N     = 6,
  parameter int LK_N     = 2,
  parameter int WD_N     = 3,
  parameter int ADDR_W   = 4,
  parameter int CLR_ADDR = 15
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick,
  input  logic                                 start,
  input  logic                                 rate_chg,
  input  logic                                 proc_done,
  input  logic                                 low_bat,
  input  logic                                 cfg_we,
  input  logic [ADDR_W-1:0]                    cfg_addr,
  input  logic [LINES+DUR_W:0]                 cfg_wdata,
  output logic [LINES-1:0]                     rx_ctl,
  output logic [2:0]                           phase,
  output logic [$clog2(WU_N+LK_N+WD_N)-1:0]    stage_idx,
  output logic                                 rx_ready,
  output logic                                 bat_low
);
  localparam int NST      = WU_N + LK_N + WD_N;
  localparam int IDX_W    = $clog2(NST);
  localparam int REG_W    = LINES + DUR_W + 1;
  localparam int LK_FIRST = WU_N;
  localparam int LK_LAST  = WU_N + LK_N - 1;
  localparam int WD_FIRST = WU_N + LK_N;
  localparam int LAST     = NST - 1;

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_WU   = 3'd1;
  localparam logic [2:0] PH_LK   = 3'd2;
  localparam logic [2:0] PH_RDY  = 3'd3;
  localparam logic [2:0] PH_WD   = 3'd4;

  logic [REG_W-1:0] cfg [NST];
  logic [2:0]       ph;
  logic [IDX_W-1:0] st;
  logic [DUR_W-1:0] cnt;
  logic             flag;

  function automatic logic [DUR_W-1:0] dur_of(input logic [REG_W-1:0] w);
    return w[LINES+DUR_W-1:LINES];
  endfunction

  for (genvar i = 0; i < NST; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg[i] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(i)) cfg[i] <= cfg_wdata;
  end

  logic [REG_W-1:0] cur;
  logic [IDX_W-1:0] nxt_st;
  logic             running, stage_end, clr_req, bat_hit;

  assign cur       = cfg[st];
  assign nxt_st    = st + IDX_W'(1);
  assign running   = (ph == PH_WU) || (ph == PH_LK) || (ph == PH_WD);
  assign stage_end = running && tick && (cnt == '0);
  assign clr_req   = cfg_we && (cfg_addr == ADDR_W'(CLR_ADDR)) && cfg_wdata[0];
  assign bat_hit   = stage_end && cur[REG_W-1] && (ph != PH_LK) && low_bat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      st  <= '0;
      cnt <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        ph  <= PH_WU;
        st  <= '0;
        cnt <= dur_of(cfg[0]);
      end
    end else if (ph == PH_RDY) begin
      if (proc_done) begin
        ph  <= PH_WD;
        st  <= IDX_W'(WD_FIRST);
        cnt <= dur_of(cfg[WD_FIRST]);
      end else if (rate_chg) begin
        ph  <= PH_LK;
        st  <= IDX_W'(LK_FIRST);
        cnt <= dur_of(cfg[LK_FIRST]);
      end
    end else if (tick) begin
      if (cnt != '0) begin
        cnt <= cnt - DUR_W'(1);
      end else if (st == IDX_W'(LK_LAST)) begin
        ph <= PH_RDY;
      end else if (st == IDX_W'(LAST)) begin
        ph <= PH_IDLE;
        st <= '0;
      end else begin
        st  <= nxt_st;
        cnt <= dur_of(cfg[nxt_st]);
        if (st == IDX_W'(WU_N - 1)) ph <= PH_LK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag <= 1'b0;
    else if (bat_hit) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;

  assign rx_ctl    = (ph == PH_IDLE) ? '0 : cur[LINES-1:0];
  assign phase     = ph;
  assign stage_idx = (ph == PH_IDLE || ph == PH_RDY) ? '0 : st;
  assign rx_ready  = (ph == PH_RDY);
  assign bat_low   = flag;

  a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |=> (ph == PH_IDLE) || (ph == PH_WU && st == '0));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick) |=> ($stable(ph) && $stable(st)));

  a_r5_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LK) |=> (ph == PH_LK || ph == PH_RDY));

  a_r6_warmdown_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WD) |=> (ph == PH_WD || ph == PH_IDLE));

  a_r6_done_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RDY && proc_done) |=> (ph == PH_WD && st == IDX_W'(WD_FIRST)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
endmodule

// File: tb/pager_rx_seq_test.sv
module pager_rx_seq_test;
  logic clk = 0, rst_n = 0, tick = 0, start = 0, rate_chg = 0, proc_done = 0, low_bat = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [14:0] cfg_wdata = 0;
  logic [5:0] rx_ctl;
  logic [2:0] phase;
  logic [3:0] stage_idx;
  logic rx_ready, bat_low;

  pager_rx_seq uut (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .rate_chg(rate_chg),
    .proc_done(proc_done), .low_bat(low_bat), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_ctl(rx_ctl), .phase(phase), .stage_idx(stage_idx),
    .rx_ready(rx_ready), .bat_low(bat_low));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] pat [11];
  logic [7:0] dur [11];
  logic       bchk [11];
  bit exp_flag = 0;

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int phase_of(input int idx);
    return (idx < 6) ? 1 : (idx < 8) ? 2 : 4;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 15'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse(input bit s, input bit r, input bit p);
    @(negedge clk); start = s; rate_chg = r; proc_done = p;
    @(negedge clk); start = 0; rate_chg = 0; proc_done = 0;
  endtask

  task automatic tick1(input bit lb, input bit clr);
    @(negedge clk); tick = 1; low_bat = lb;
    if (clr) begin cfg_we = 1; cfg_addr = 4'd15; cfg_wdata = 15'd1; end
    @(negedge clk); tick = 0; low_bat = 0; cfg_we = 0;
  endtask

  task automatic walk(input int idx);
    bit lb, clr;
    int eph;
    eph = phase_of(idx);
    chk_eq("R2 phase", phase, eph);
    chk_eq("R2 stage", stage_idx, idx);
    chk_eq("R4 pattern", rx_ctl, pat[idx]);
    @(negedge clk);
    chk_eq("R3 no tick hold", stage_idx, idx);
    for (int k = 0; k < dur[idx]; k++) tick1(1'b0, 1'b0);
    if (dur[idx] != 0) chk_eq("R3 duration not yet over", stage_idx, idx);
    lb  = 1'($urandom % 2);
    clr = ($urandom % 4) == 0;
    tick1(lb, clr);
    if (bchk[idx] && eph != 2 && lb) exp_flag = 1;
    else if (clr) exp_flag = 0;
    chk_eq("R8 R9 battery flag", bat_low, exp_flag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5591));
    repeat (3) @(negedge clk);
    chk_eq("R1 phase", phase, 0);
    chk_eq("R1 rx_ctl", rx_ctl, 0);
    chk_eq("R1 stage", stage_idx, 0);
    chk_eq("R1 ready", rx_ready, 0);
    chk_eq("R1 flag", bat_low, 0);
    rst_n = 1;
    pulse(1'b1, 1'b0, 1'b0);
    chk_eq("R1 zero words give one-tick stage 0", stage_idx, 0);
    chk_eq("R1 zero pattern", rx_ctl, 0);
    for (int i = 0; i < 11; i++) tick1(1'b0, 1'b0);
    chk_eq("R1 walks zero words to ready", phase, 3);
    pulse(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick1(1'b0, 1'b0);
    chk_eq("R6 back to idle", phase, 0);

    for (int it = 0; it < 5; it++) begin
      for (int i = 0; i < 11; i++) begin
        pat[i]  = 6'($urandom);
        dur[i]  = 8'($urandom % 5);
        bchk[i] = 1'($urandom % 2);
      end
      if (it == 0) dur[3] = 8'd255;
      if (it == 1) begin dur[0] = 0; dur[7] = 0; dur[10] = 0; bchk[6] = 1; bchk[7] = 1; end
      for (int i = 0; i < 11; i++) wr(i, {bchk[i], dur[i], pat[i]});
      for (int a = 11; a < 15; a++) wr(a, 15'h7fff);
      pulse(1'b1, 1'b0, 1'b0);
      chk_eq("R2 start enters warm-up", phase, 1);
      pulse(1'b1, 1'b1, 1'b1);
      chk_eq("R7 requests ignored in warm-up", phase, 1);
      chk_eq("R7 stage kept", stage_idx, 0);
      for (int s = 0; s < 8; s++) walk(s);
      chk_eq("R2 ready phase", phase, 3);
      chk_eq("R2 rx_ready", rx_ready, 1);
      chk_eq("R2 stage in ready", stage_idx, 0);
      chk_eq("R4 ready pattern R10 no alias", rx_ctl, pat[7]);
      pulse(1'b1, 1'b0, 1'b0);
      chk_eq("R7 start ignored in ready", phase, 3);
      pulse(1'b0, 1'b1, 1'b0);
      chk_eq("R5 rate change enters lock", phase, 2);
      walk(6); walk(7);
      chk_eq("R5 back to ready", phase, 3);
      pulse(1'b0, (it % 2) == 1, 1'b1);
      chk_eq("R6 done wins", phase, 4);
      for (int s = 8; s < 11; s++) walk(s);
      chk_eq("R6 idle after warm-down", phase, 0);
      chk_eq("R4 idle lines", rx_ctl, 0);
      chk_eq("R6 rx_ready low", rx_ready, 0);
      wr(15, 0);
      chk_eq("R9 zero write keeps flag", bat_low, exp_flag);
      wr(15, 1);
      exp_flag = 0;
      chk_eq("R9 clear", bat_low, 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule